// File: doc/BRIEF.md
# Multi-Mode ADC Channel Sequencer

This block sits between a single successive-approximation converter and the four analog inputs it shares. It decides which input the converter samples next and which of four result registers receives each result. It also decides when a pass counts as finished, which sets a sticky interrupt flag. A start pulse begins a sequence. The converter handshake is a one-cycle `conv_req_o` pulse out and a one-cycle `done_i` pulse back, carrying the 8-bit result. The mode and channel settings are latched when a sequence starts.

There are six modes. The fixed-channel modes and the scan modes pick channels from the channel mask. Dual mode uses the two channel indices instead. Two things depend on the mode: where each result lands (in the register that matches the channel, or in a rotating slot) and how often the interrupt fires (once per conversion, once per four conversions, or once per pass over the mask).

The controller has four states:
- IDLE: no sequence is running.
- REQ: the block issues the conversion request.
- WAIT: the block waits for the converter to report done.
- HOLD: used only in step mode; the block waits for the next start.

The transitions are:
- IDLE→REQ on an accepted start.
- REQ→WAIT always.
- WAIT→REQ when the sequence continues.
- WAIT→IDLE when the sequence ends or a stop is pending.
- WAIT→HOLD in step mode when more channels remain.
- HOLD→REQ on start.
- HOLD→IDLE on stop.

Top module: `adc_seq_top`

## Requirements
- R1: Fixed single mode (`mode_i`=0) converts the lowest set channel of the mask once, writes the result into the register with that channel's index, sets the interrupt and returns to idle.
- R2: Fixed continuous mode (`mode_i`=1) converts the lowest set channel of the mask repeatedly. Results go into registers 0, 1, 2, 3 in turn, then wrap around. The interrupt sets after every fourth result and not before.
- R3: Scan single mode (`mode_i`=2) converts every channel set in the mask once, in ascending index order. Each result goes into the register with its channel's index. The interrupt sets after the last channel, and the block then goes idle.
- R4: Scan continuous mode (`mode_i`=3) behaves like R3, but restarts from the lowest set channel after each pass and sets the interrupt at the end of every pass.
- R5: Dual mode (`mode_i`=4) converts channel A (`chan_a_i`) and channel B (`chan_b_i`) alternately, starting with A. Results go into registers 0, 1, 2, 3 in turn, then wrap around. The interrupt sets after every fourth result.
- R6: Step mode (`mode_i`=5) converts one masked channel per start, in ascending order. The interrupt sets after each conversion. `busy_o` stays high while the block waits for the next start, and the block goes idle after the last channel.
- R7: Scan single mode with a single bit set in the mask gives the same result as fixed single mode: one conversion, into that channel's register.
- R8: A start in a mask-based mode with a zero mask, or with `mode_i` 6 or 7, issues no request and leaves `busy_o` low.
- R9: A stop request lets the conversion in progress finish and store its result, then returns the block to idle. All stored results are kept.
- R10: Once set, the interrupt stays high until an `irq_clr_i` pulse. A clear pulse in the same cycle as a new completion is overridden: the interrupt stays set.
- R11: A start pulse during a running conversion is ignored.
- R12: `conv_req_o` is high for exactly one cycle per conversion and only while busy. `chan_sel_o` holds steady until `done_i` arrives.
- R13: After reset, `busy_o`, `conv_req_o` and `irq_o` are low, and all result registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode; codes 0 to 5 as in R1 to R6 |
| chan_mask_i | input | 4 | Channel selection mask, bit i selects channel i |
| chan_a_i | input | 2 | First channel in dual mode |
| chan_b_i | input | 2 | Second channel in dual mode |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop request pulse |
| done_i | input | 1 | Converter done pulse |
| result_i | input | 8 | Converter result, valid while `done_i` is high |
| irq_clr_i | input | 1 | Interrupt clear (write one to clear) |
| chan_sel_o | output | 2 | Channel select for the input multiplexer |
| conv_req_o | output | 1 | Conversion request pulse |
| result_o | output | 32 | Result registers; register i is bits [8i+7:8i] |
| busy_o | output | 1 | High while a sequence is running |
| irq_o | output | 1 | Sticky conversion-complete interrupt |

## Verification
The bench builds the block with its default parameters: four channels and 8-bit results. With four registers, both the fixed continuous mode and the dual mode wrap back to register 0 within seven or fewer conversions. That makes overwrite ordering and the stop point checkable in short runs. The converter model tags each result with its channel and a request sequence number, so the check for every register shows both which channel was sampled and in which order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        M_FIX_ONE  = 3'd0,
        M_FIX_RUN  = 3'd1,
        M_SCAN_ONE = 3'd2,
        M_SCAN_RUN = 3'd3,
        M_DUAL     = 3'd4,
        M_STEP     = 3'd5
    } seq_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_HOLD = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_seq_pick.sv
// Finds the lowest set mask bit whose index is at or above a given start index.
module adc_seq_pick #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask_i,
    input  logic [CW:0]    from_i,
    output logic           found_o,
    output logic [CW-1:0]  idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i] && ((CW+1)'(i) >= from_i)) begin
                found_o = 1'b1;
                idx_o   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_seq_bank.sv
// Result register bank, one write port.
module adc_seq_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CW-1:0]     wr_idx_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [NCH*DW-1:0] regs_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_reg
        logic [DW-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en_i && (wr_idx_i == CW'(g)))
                val_q <= wr_data_i;
        end
        assign regs_o[g*DW +: DW] = val_q;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencing state machine: channel order, result slot, interrupt cadence.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     mode_i,
    input  logic [NCH-1:0] mask_i,
    input  logic [CW-1:0]  chan_a_i,
    input  logic [CW-1:0]  chan_b_i,
    input  logic           start_i,
    input  logic           stop_i,
    input  logic           done_i,
    input  logic           irq_clr_i,
    output logic [CW-1:0]  chan_sel_o,
    output logic           conv_req_o,
    output logic           wr_en_o,
    output logic [CW-1:0]  wr_idx_o,
    output logic           busy_o,
    output logic           irq_o
);
    seq_state_e     state_q, state_d;
    seq_mode_e      mode_q, mode_d;
    logic [NCH-1:0] mask_q, mask_d;
    logic [CW-1:0]  chan_q, chan_d;
    logic [CW-1:0]  slot_q, slot_d;
    logic [CW-1:0]  a_q, a_d, b_q, b_d;
    logic           half_q, half_d;
    logic           stop_q, stop_d;
    logic           irq_q, irq_set;

    logic           first_found, next_found;
    logic [CW-1:0]  first_idx, next_idx;
    logic [NCH-1:0] pick_mask;
    logic           mode_ok, accept;
    logic           slot_last;

    assign pick_mask = (state_q == S_IDLE) ? mask_i : mask_q;

    adc_seq_pick #(.NCH(NCH)) first_i (
        .mask_i (pick_mask),
        .from_i ('0),
        .found_o(first_found),
        .idx_o  (first_idx)
    );

    adc_seq_pick #(.NCH(NCH)) next_i (
        .mask_i (mask_q),
        .from_i ({1'b0, chan_q} + (CW+1)'(1)),
        .found_o(next_found),
        .idx_o  (next_idx)
    );

    assign mode_ok   = (mode_i <= 3'd5);
    assign accept    = mode_ok && ((mode_i == 3'(M_DUAL)) || first_found);
    assign slot_last = (slot_q == CW'(NCH - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        mask_d  = mask_q;
        chan_d  = chan_q;
        slot_d  = slot_q;
        a_d     = a_q;
        b_d     = b_q;
        half_d  = half_q;
        stop_d  = stop_q | (stop_i && (state_q != S_IDLE));
        irq_set = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                stop_d = 1'b0;
                if (start_i && accept) begin
                    mode_d  = seq_mode_e'(mode_i);
                    mask_d  = mask_i;
                    a_d     = chan_a_i;
                    b_d     = chan_b_i;
                    slot_d  = '0;
                    half_d  = 1'b0;
                    chan_d  = (mode_i == 3'(M_DUAL)) ? chan_a_i : first_idx;
                    state_d = S_REQ;
                end
            end
            S_REQ: state_d = S_WAIT;
            S_WAIT: begin
                if (done_i) begin
                    case (mode_q)
                        M_FIX_ONE: begin
                            irq_set = 1'b1;
                            state_d = S_IDLE;
                        end
                        M_FIX_RUN: begin
                            slot_d  = slot_q + CW'(1);
                            irq_set = slot_last;
                            state_d = stop_d ? S_IDLE : S_REQ;
                        end
                        M_DUAL: begin
                            slot_d  = slot_q + CW'(1);
                            half_d  = ~half_q;
                            chan_d  = half_q ? a_q : b_q;
                            irq_set = slot_last;
                            state_d = stop_d ? S_IDLE : S_REQ;
                        end
                        M_SCAN_ONE: begin
                            if (next_found) begin
                                chan_d  = next_idx;
                                state_d = stop_d ? S_IDLE : S_REQ;
                            end else begin
                                irq_set = 1'b1;
                                state_d = S_IDLE;
                            end
                        end
                        M_SCAN_RUN: begin
                            if (next_found) begin
                                chan_d = next_idx;
                            end else begin
                                irq_set = 1'b1;
                                chan_d  = first_idx;
                            end
                            state_d = stop_d ? S_IDLE : S_REQ;
                        end
                        M_STEP: begin
                            irq_set = 1'b1;
                            if (next_found && !stop_d) begin
                                chan_d  = next_idx;
                                state_d = S_HOLD;
                            end else begin
                                state_d = S_IDLE;
                            end
                        end
                        default: state_d = S_IDLE;
                    endcase
                end
            end
            S_HOLD: begin
                if (stop_d)
                    state_d = S_IDLE;
                else if (start_i)
                    state_d = S_REQ;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= M_FIX_ONE;
            mask_q  <= '0;
            chan_q  <= '0;
            slot_q  <= '0;
            a_q     <= '0;
            b_q     <= '0;
            half_q  <= 1'b0;
            stop_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            mask_q  <= mask_d;
            chan_q  <= chan_d;
            slot_q  <= slot_d;
            a_q     <= a_d;
            b_q     <= b_d;
            half_q  <= half_d;
            stop_q  <= stop_d;
            irq_q   <= irq_set | (irq_q & ~irq_clr_i);
        end
    end

    // outputs
    always_comb begin
        chan_sel_o = chan_q;
        conv_req_o = (state_q == S_REQ);
        busy_o     = (state_q != S_IDLE);
        irq_o      = irq_q;
        wr_en_o    = (state_q == S_WAIT) && done_i;
        wr_idx_o   = ((mode_q == M_FIX_RUN) || (mode_q == M_DUAL)) ? slot_q : chan_q;
    end

    p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |=> !conv_req_o);
    p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> busy_o);
    p_chan_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !done_i) |=> $stable(chan_sel_o));
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);
    p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (mode_i != 3'(M_DUAL)) && (mask_i == '0)) |=> !busy_o);
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !start_i) |=> !conv_req_o);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [NCH-1:0]    chan_mask_i,
    input  logic [CW-1:0]     chan_a_i,
    input  logic [CW-1:0]     chan_b_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              done_i,
    input  logic [DW-1:0]     result_i,
    input  logic              irq_clr_i,
    output logic [CW-1:0]     chan_sel_o,
    output logic              conv_req_o,
    output logic [NCH*DW-1:0] result_o,
    output logic              busy_o,
    output logic              irq_o
);
    logic          wr_en;
    logic [CW-1:0] wr_idx;

    adc_seq_fsm #(.NCH(NCH)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .mask_i    (chan_mask_i),
        .chan_a_i  (chan_a_i),
        .chan_b_i  (chan_b_i),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .done_i    (done_i),
        .irq_clr_i (irq_clr_i),
        .chan_sel_o(chan_sel_o),
        .conv_req_o(conv_req_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .busy_o    (busy_o),
        .irq_o     (irq_o)
    );

    adc_seq_bank #(.NCH(NCH), .DW(DW)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(result_i),
        .regs_o   (result_o)
    );
endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [3:0]  chan_mask_i = '0;
    logic [1:0]  chan_a_i = '0, chan_b_i = '0;
    logic        start_i = 1'b0, stop_i = 1'b0, done_i = 1'b0, irq_clr_i = 1'b0;
    logic [7:0]  result_i = '0;
    logic [1:0]  chan_sel_o;
    logic        conv_req_o, busy_o, irq_o;
    logic [31:0] result_o;

    int errors = 0;
    int checks = 0;
    int nreq = 0;
    int cd = 0;
    logic [7:0] pend = '0;

    always #2 clk = ~clk;

    adc_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .chan_mask_i(chan_mask_i),
        .chan_a_i(chan_a_i), .chan_b_i(chan_b_i), .start_i(start_i), .stop_i(stop_i),
        .done_i(done_i), .result_i(result_i), .irq_clr_i(irq_clr_i),
        .chan_sel_o(chan_sel_o), .conv_req_o(conv_req_o), .result_o(result_o),
        .busy_o(busy_o), .irq_o(irq_o)
    );

    // converter model: done three cycles after request, result = {channel, request number}
    initial begin
        forever begin
            @(negedge clk);
            done_i = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    done_i   = 1'b1;
                    result_i = pend;
                end
            end
            if (conv_req_o) begin
                pend = {chan_sel_o, 6'(nreq)};
                nreq++;
                cd = 3;
            end
        end
    end

    function automatic logic [7:0] expv(input int ch, input int k);
        return {2'(ch), 6'(k)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int reg_of(input int i);
        return int'(result_o[i*8 +: 8]);
    endfunction

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_req(input int n);
        while (nreq < n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 busy", busy_o, 0);
        chk("R13 req", conv_req_o, 0);
        chk("R13 irq", irq_o, 0);
        chk("R13 regs", int'(result_o), 0);
    endtask

    task automatic t_fix_one();
        int base = nreq;
        mode_i = 3'd0; chan_mask_i = 4'b0110;
        pulse_start();
        wait_idle();
        chk("R1 count", nreq - base, 1);
        chk("R1 reg1", reg_of(1), expv(1, base));
        chk("R1 irq", irq_o, 1);
        repeat (10) @(negedge clk);
        chk("R10 sticky", irq_o, 1);
        clear_irq();
        chk("R10 cleared", irq_o, 0);
    endtask

    task automatic t_busy_start();
        int base = nreq;
        mode_i = 3'd0; chan_mask_i = 4'b0100;
        pulse_start();
        @(negedge clk);
        pulse_start();
        wait_idle();
        chk("R11 count", nreq - base, 1);
        chk("R11 reg2", reg_of(2), expv(2, base));
        clear_irq();
    endtask

    task automatic t_fix_run();
        int base = nreq;
        mode_i = 3'd1; chan_mask_i = 4'b1010;
        pulse_start();
        wait_req(base + 4);
        chk("R2 no early irq", irq_o, 0);
        wait_req(base + 7);
        pulse_stop();
        wait_idle();
        chk("R9 count", nreq - base, 7);
        chk("R2 reg0", reg_of(0), expv(1, base + 4));
        chk("R2 reg1", reg_of(1), expv(1, base + 5));
        chk("R2 reg2", reg_of(2), expv(1, base + 6));
        chk("R2 reg3", reg_of(3), expv(1, base + 3));
        chk("R2 irq", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_scan_one();
        int base = nreq;
        mode_i = 3'd2; chan_mask_i = 4'b1011;
        pulse_start();
        wait_idle();
        chk("R3 count", nreq - base, 3);
        chk("R3 reg0", reg_of(0), expv(0, base));
        chk("R3 reg1", reg_of(1), expv(1, base + 1));
        chk("R3 reg3", reg_of(3), expv(3, base + 2));
        chk("R3 irq", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_scan_lone();
        int base = nreq;
        mode_i = 3'd2; chan_mask_i = 4'b1000;
        pulse_start();
        wait_idle();
        chk("R7 count", nreq - base, 1);
        chk("R7 reg3", reg_of(3), expv(3, base));
        chk("R7 irq", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_scan_run();
        int base = nreq;
        mode_i = 3'd3; chan_mask_i = 4'b0110;
        pulse_start();
        wait_req(base + 5);
        chk("R4 pass irq", irq_o, 1);
        pulse_stop();
        wait_idle();
        chk("R4 count", nreq - base, 5);
        chk("R4 reg1", reg_of(1), expv(1, base + 4));
        chk("R4 reg2", reg_of(2), expv(2, base + 3));
        clear_irq();
    endtask

    task automatic t_dual();
        int base = nreq;
        mode_i = 3'd4; chan_mask_i = 4'b0000; chan_a_i = 2'd3; chan_b_i = 2'd0;
        pulse_start();
        wait_req(base + 6);
        pulse_stop();
        wait_idle();
        chk("R5 count", nreq - base, 6);
        chk("R5 reg0", reg_of(0), expv(3, base + 4));
        chk("R5 reg1", reg_of(1), expv(0, base + 5));
        chk("R5 reg2", reg_of(2), expv(3, base + 2));
        chk("R5 reg3", reg_of(3), expv(0, base + 3));
        chk("R5 irq", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_step();
        int base = nreq;
        mode_i = 3'd5; chan_mask_i = 4'b0101;
        pulse_start();
        repeat (10) @(negedge clk);
        chk("R6 first count", nreq - base, 1);
        chk("R6 hold busy", busy_o, 1);
        chk("R6 first irq", irq_o, 1);
        chk("R6 reg0", reg_of(0), expv(0, base));
        clear_irq();
        pulse_start();
        wait_idle();
        chk("R6 second count", nreq - base, 2);
        chk("R6 reg2", reg_of(2), expv(2, base + 1));
        chk("R6 second irq", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_ignored_starts();
        int base = nreq;
        mode_i = 3'd2; chan_mask_i = 4'b0000;
        pulse_start();
        repeat (6) @(negedge clk);
        chk("R8 zero mask req", nreq - base, 0);
        chk("R8 zero mask busy", busy_o, 0);
        mode_i = 3'd7; chan_mask_i = 4'b1111;
        pulse_start();
        repeat (6) @(negedge clk);
        chk("R8 bad mode req", nreq - base, 0);
        chk("R8 bad mode busy", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fix_one();
        t_busy_start();
        t_fix_run();
        t_scan_one();
        t_scan_lone();
        t_scan_run();
        t_dual();
        t_step();
        t_ignored_starts();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule